// File: doc/BRIEF.md
# Step-Down Regulator Start/Stop and Protection Sequencer

This block is the digital sequencer of a current-mode step-down regulator. It watches an enable level, a supply-good flag (already filtered with hysteresis by an analog comparator), a digitized feedback code and a digitized junction-temperature code. From these it drives a reference-ramp code for an external DAC, a select flag that chooses between that ramp and the fixed reference, a current-sink enable, and a two-bit gate command for the power-stage drivers.

A start begins only with supply good, enable high and a cool die. The ramp climbs from zero to a top code slightly above the reference code. The ramp stands in for the reference until the two are equal, and current sinking stays off until the feedback first reaches the target. A stop brings the same ramp back down to zero at the same rate. A stop is caused by enable falling, by a filtered under-voltage fault or by a thermal fault. What happens at the end of the stop depends on the cause: the low-side switch is held on, a restart is timed after a delay, or both switches are turned off.

An over-voltage clamp turns the low-side switch on and lets go once the feedback is back inside a hysteresis band. A loss of supply good drops the block to the off state at once, with no soft-stop. All codes share one scale. With the default parameters the reference is code 819, the ramp top is 973, and one ramp step lasts 20 cycles of a 10 MHz clock, so a full ramp takes about 2 ms.

Top module: `buck_seq_ctrl`

## Requirements
- R1: After reset, and whenever the block is off, gate_cmd is 2'b00 (both switches off), ramp_code is 0, sink_en is 0 and ramp_sel is 1. The block leaves the off state only when en=1, pg_ok=1 and the die is not hot. It then drives gate_cmd 2'b01 (normal switching).
- R2: During a soft-start, ramp_code rises by exactly one every STEP_DIV cycles from 0 up to TOP_CODE (973) and never goes past it. ramp_sel is 1 while ramp_code < REF_CODE (819) and 0 once ramp_code >= REF_CODE. In regulation, ramp_sel is 0 and ramp_code stays at TOP_CODE.
- R3: During a soft-start, sink_en is 0 until fb_code has reached REF_CODE. It then goes to 1 within two cycles and stays at 1 for the rest of the start, through regulation and through the following soft-stop.
- R4: When en falls during a start or in regulation, a soft-stop begins. ramp_sel is 1, gate_cmd stays 2'b01 and ramp_code falls by one every STEP_DIV cycles to 0. After that, gate_cmd is held at 2'b10 (low-side on) with ramp_code 0 until en returns high, and then a new soft-start begins.
- R5: Under-voltage is checked only in regulation. A run of at least UV_FILT (20) consecutive cycles with fb_code < REF_CODE/2 (409) starts a soft-stop. Shorter runs are ignored. A low fb_code during a soft-start causes no stop.
- R6: At the end of a soft-stop caused by under-voltage, gate_cmd is 2'b10 for HICCUP_CYC cycles. A new soft-start then begins on its own, with no change on en.
- R7: While the block is starting, regulating or stopping, fb_code > floor(REF_CODE*123/100) (1007) drives gate_cmd to 2'b10 by the second clock edge. The clamp stays on while fb_code >= floor(REF_CODE*105/100) (859). It releases to 2'b01 once fb_code falls below that value, and the sequence resumes without a restart.
- R8: temp_code >= TEMP_TRIP (150) sets the hot flag. If the block is starting or regulating, a soft-stop follows. That stop ends with gate_cmd 2'b00. No new start is allowed until temp_code <= TEMP_TRIP-TEMP_HYST (110).
- R9: When pg_ok is 0 at a clock edge, gate_cmd becomes 2'b00 and ramp_code becomes 0 at that same edge, with no soft-stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Regulator enable level |
| pg_ok | input | 1 | Supply-good flag, hysteresis already applied |
| fb_code | input | CODE_W | Digitized feedback voltage |
| temp_code | input | TEMP_W | Digitized junction temperature, one code per degree |
| ramp_code | output | CODE_W | Reference-ramp code for the DAC |
| ramp_sel | output | 1 | 1: error amplifier uses the ramp; 0: uses the fixed reference |
| sink_en | output | 1 | Allows the converter to sink current |
| gate_cmd | output | 2 | 00 both off, 01 normal switching, 10 low-side forced on |

## Verification
The sequence is driven through each way into and out of regulation: an enable-driven stop, a filtered under-voltage stop with its hiccup restart, a thermal stop with recovery through the hysteresis band, and a sudden loss of supply good. Feedback is held below target during one start and brought up during another. This shows whether the sink gate follows the feedback or only the ramp. Under-voltage runs shorter and longer than the filter separate a glitch from a real fault. Feedback values above the trip, inside the band and below the release separate a latched clamp from one with hysteresis. Temperatures between the clear and trip points show that the restart waits for the lower threshold.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

    // Gate-stage command seen by the drivers
    typedef enum logic [1:0] {
        GATE_OFF    = 2'b00,
        GATE_SWITCH = 2'b01,
        GATE_LOWON  = 2'b10
    } gate_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,   // off, waiting for start conditions
        ST_RISE,   // soft-start ramp
        ST_REG,    // regulation on the fixed reference
        ST_FALL,   // soft-stop ramp
        ST_PARK,   // low-side held after an enable stop
        ST_WAIT    // hiccup delay after an under-voltage stop
    } seq_state_e;

    // Command from the sequencer to the ramp engine
    typedef enum logic [1:0] {
        RC_CLEAR,
        RC_HOLD,
        RC_UP,
        RC_DOWN
    } ramp_cmd_e;

    // Reason the current soft-stop was started
    typedef enum logic [1:0] {
        WHY_EN,
        WHY_UV,
        WHY_OT
    } stop_why_e;

    // Fault flags handed from the monitor to the sequencer
    typedef struct packed {
        logic uv_trip;
        logic ov_clamp;
        logic hot;
    } fault_t;

    // Integer percentage of a code, rounded down
    function automatic int scale_pct(input int base, input int pct);
        return (base * pct) / 100;
    endfunction

endpackage

// File: rtl/buck_seq_ramp.sv
module buck_seq_ramp
    import buck_seq_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int TOP_CODE = 973,
    parameter int STEP_DIV = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  ramp_cmd_e         cmd,
    output logic [CODE_W-1:0] ramp,
    output logic              at_top,
    output logic              at_zero
);
    localparam int PRE_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(STEP_DIV - 1);
    localparam logic [CODE_W-1:0] TOP_C    = CODE_W'(TOP_CODE);

    logic [PRE_W-1:0] pre;
    logic             tick;

    assign tick    = (pre == PRE_LAST);
    assign at_top  = (ramp == TOP_C);
    assign at_zero = (ramp == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ramp <= '0;
            pre  <= '0;
        end else begin
            case (cmd)
                RC_CLEAR: begin
                    ramp <= '0;
                    pre  <= '0;
                end
                RC_HOLD: pre <= '0;
                RC_UP: begin
                    if (tick) begin
                        pre <= '0;
                        if (!at_top) ramp <= ramp + 1'b1;
                    end else begin
                        pre <= pre + 1'b1;
                    end
                end
                RC_DOWN: begin
                    if (tick) begin
                        pre <= '0;
                        if (!at_zero) ramp <= ramp - 1'b1;
                    end else begin
                        pre <= pre + 1'b1;
                    end
                end
                default: pre <= '0;
            endcase
        end
    end

endmodule

// File: rtl/buck_seq_faults.sv
module buck_seq_faults
    import buck_seq_pkg::*;
#(
    parameter int CODE_W    = 10,
    parameter int TEMP_W    = 8,
    parameter int REF_CODE  = 819,
    parameter int UV_FILT   = 20,
    parameter int TEMP_TRIP = 150,
    parameter int TEMP_HYST = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] fb,
    input  logic [TEMP_W-1:0] temp,
    input  logic              uv_arm,
    input  logic              ov_arm,
    output fault_t            flt
);
    localparam logic [CODE_W-1:0] UV_THR  = CODE_W'(REF_CODE / 2);
    localparam logic [CODE_W-1:0] OV_TRIP = CODE_W'(scale_pct(REF_CODE, 123));
    localparam logic [CODE_W-1:0] OV_REL  = CODE_W'(scale_pct(REF_CODE, 105));
    localparam logic [TEMP_W-1:0] T_TRIP  = TEMP_W'(TEMP_TRIP);
    localparam logic [TEMP_W-1:0] T_CLR   = TEMP_W'(TEMP_TRIP - TEMP_HYST);
    localparam int FILT_W = $clog2(UV_FILT + 1);
    localparam logic [FILT_W-1:0] FILT_LAST = FILT_W'(UV_FILT - 1);

    logic [FILT_W-1:0] low_run;

    // Over-voltage clamp with release hysteresis, never latched
    always_ff @(posedge clk) begin
        if (rst || !ov_arm)       flt.ov_clamp <= 1'b0;
        else if (fb > OV_TRIP)    flt.ov_clamp <= 1'b1;
        else if (fb < OV_REL)     flt.ov_clamp <= 1'b0;
    end

    // Under-voltage run-length filter; an active clamp keeps it cleared
    always_ff @(posedge clk) begin
        if (rst || !uv_arm || flt.ov_clamp || fb >= UV_THR) begin
            low_run     <= '0;
            flt.uv_trip <= 1'b0;
        end else if (low_run == FILT_LAST) begin
            flt.uv_trip <= 1'b1;
        end else begin
            low_run <= low_run + 1'b1;
        end
    end

    // Thermal flag with hysteresis
    always_ff @(posedge clk) begin
        if (rst)             flt.hot <= 1'b0;
        else if (flt.hot)    flt.hot <= (temp > T_CLR);
        else                 flt.hot <= (temp >= T_TRIP);
    end

endmodule

// File: rtl/buck_seq_fsm.sv
module buck_seq_fsm
    import buck_seq_pkg::*;
#(
    parameter int CODE_W     = 10,
    parameter int REF_CODE   = 819,
    parameter int HICCUP_CYC = 20000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              pg_ok,
    input  logic [CODE_W-1:0] fb,
    input  logic [CODE_W-1:0] ramp,
    input  logic              at_top,
    input  logic              at_zero,
    input  fault_t            flt,
    output ramp_cmd_e         cmd,
    output logic              uv_arm,
    output logic              ov_arm,
    output gate_e             gate,
    output logic              ramp_sel,
    output logic              sink_en
);
    localparam logic [CODE_W-1:0] REF_C = CODE_W'(REF_CODE);
    localparam int WAIT_W = $clog2(HICCUP_CYC + 1);
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(HICCUP_CYC - 1);

    seq_state_e        state, nxt;
    stop_why_e         why, why_nxt;
    logic              reached;
    logic [WAIT_W-1:0] wait_cnt;
    logic              wait_done;
    logic              may_start;

    assign wait_done = (wait_cnt == WAIT_LAST);
    assign may_start = en && !flt.hot;

    always_comb begin
        nxt     = state;
        why_nxt = why;
        if (!pg_ok) begin
            nxt = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (may_start) nxt = ST_RISE;
                ST_RISE: begin
                    if (flt.hot) begin
                        nxt = ST_FALL;  why_nxt = WHY_OT;
                    end else if (!en) begin
                        nxt = ST_FALL;  why_nxt = WHY_EN;
                    end else if (at_top) begin
                        nxt = ST_REG;
                    end
                end
                ST_REG: begin
                    if (flt.hot) begin
                        nxt = ST_FALL;  why_nxt = WHY_OT;
                    end else if (!en) begin
                        nxt = ST_FALL;  why_nxt = WHY_EN;
                    end else if (flt.uv_trip) begin
                        nxt = ST_FALL;  why_nxt = WHY_UV;
                    end
                end
                ST_FALL: begin
                    if (at_zero) begin
                        case (why)
                            WHY_EN:  nxt = ST_PARK;
                            WHY_UV:  nxt = ST_WAIT;
                            default: nxt = ST_IDLE;
                        endcase
                    end
                end
                ST_PARK: if (may_start) nxt = ST_RISE;
                ST_WAIT: if (wait_done) nxt = may_start ? ST_RISE : ST_PARK;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            why      <= WHY_EN;
            reached  <= 1'b0;
            wait_cnt <= '0;
        end else begin
            state    <= nxt;
            why      <= why_nxt;
            wait_cnt <= (state == ST_WAIT) ? wait_cnt + 1'b1 : '0;
            if (state == ST_IDLE || state == ST_PARK || state == ST_WAIT)
                reached <= 1'b0;
            else if (state == ST_RISE && fb >= REF_C)
                reached <= 1'b1;
        end
    end

    // Ramp command: a supply loss clears the ramp at the same edge
    always_comb begin
        if (!pg_ok) cmd = RC_CLEAR;
        else begin
            case (state)
                ST_RISE: cmd = RC_UP;
                ST_REG:  cmd = RC_HOLD;
                ST_FALL: cmd = RC_DOWN;
                default: cmd = RC_CLEAR;
            endcase
        end
    end

    assign uv_arm = (state == ST_REG);
    assign ov_arm = (state == ST_RISE) || (state == ST_REG) || (state == ST_FALL);

    always_comb begin
        gate     = GATE_OFF;
        ramp_sel = 1'b1;
        sink_en  = 1'b0;
        case (state)
            ST_RISE: begin
                gate     = flt.ov_clamp ? GATE_LOWON : GATE_SWITCH;
                ramp_sel = (ramp < REF_C);
                sink_en  = reached;
            end
            ST_REG: begin
                gate     = flt.ov_clamp ? GATE_LOWON : GATE_SWITCH;
                ramp_sel = 1'b0;
                sink_en  = 1'b1;
            end
            ST_FALL: begin
                gate     = flt.ov_clamp ? GATE_LOWON : GATE_SWITCH;
                sink_en  = 1'b1;
            end
            ST_PARK, ST_WAIT: gate = GATE_LOWON;
            default: gate = GATE_OFF;
        endcase
    end

endmodule

// File: rtl/buck_seq_ctrl.sv
module buck_seq_ctrl
    import buck_seq_pkg::*;
#(
    parameter int CODE_W     = 10,
    parameter int TEMP_W     = 8,
    parameter int REF_CODE   = 819,
    parameter int TOP_CODE   = 973,
    parameter int STEP_DIV   = 20,
    parameter int UV_FILT    = 20,
    parameter int HICCUP_CYC = 20000,
    parameter int TEMP_TRIP  = 150,
    parameter int TEMP_HYST  = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              pg_ok,
    input  logic [CODE_W-1:0] fb_code,
    input  logic [TEMP_W-1:0] temp_code,
    output logic [CODE_W-1:0] ramp_code,
    output logic              ramp_sel,
    output logic              sink_en,
    output logic [1:0]        gate_cmd
);
    ramp_cmd_e cmd;
    fault_t    flt;
    gate_e     gate;
    logic      at_top, at_zero, uv_arm, ov_arm;

    buck_seq_ramp #(
        .CODE_W(CODE_W), .TOP_CODE(TOP_CODE), .STEP_DIV(STEP_DIV)
    ) u_ramp (
        .clk(clk), .rst(rst), .cmd(cmd),
        .ramp(ramp_code), .at_top(at_top), .at_zero(at_zero)
    );

    buck_seq_faults #(
        .CODE_W(CODE_W), .TEMP_W(TEMP_W), .REF_CODE(REF_CODE),
        .UV_FILT(UV_FILT), .TEMP_TRIP(TEMP_TRIP), .TEMP_HYST(TEMP_HYST)
    ) u_faults (
        .clk(clk), .rst(rst), .fb(fb_code), .temp(temp_code),
        .uv_arm(uv_arm), .ov_arm(ov_arm), .flt(flt)
    );

    buck_seq_fsm #(
        .CODE_W(CODE_W), .REF_CODE(REF_CODE), .HICCUP_CYC(HICCUP_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst), .en(en), .pg_ok(pg_ok), .fb(fb_code),
        .ramp(ramp_code), .at_top(at_top), .at_zero(at_zero), .flt(flt),
        .cmd(cmd), .uv_arm(uv_arm), .ov_arm(ov_arm), .gate(gate),
        .ramp_sel(ramp_sel), .sink_en(sink_en)
    );

    assign gate_cmd = gate;

endmodule

// File: rtl/buck_seq_ctrl_chk.sv
module buck_seq_ctrl_chk
    import buck_seq_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int REF_CODE = 819,
    parameter int TOP_CODE = 973
) (
    input logic              clk,
    input logic              rst,
    input logic              pg_ok,
    input logic [CODE_W-1:0] fb_code,
    input logic [CODE_W-1:0] ramp_code,
    input logic              ramp_sel,
    input logic              sink_en,
    input logic [1:0]        gate_cmd
);
    localparam logic [CODE_W-1:0] REF_C   = CODE_W'(REF_CODE);
    localparam logic [CODE_W-1:0] TOP_C   = CODE_W'(TOP_CODE);
    localparam logic [CODE_W-1:0] OV_TRIP = CODE_W'(scale_pct(REF_CODE, 123));
    localparam logic [CODE_W-1:0] ONE     = CODE_W'(1);

    // R9: supply loss gives both switches off and a cleared ramp at the next edge
    p_supply_drop_r9: assert property (@(posedge clk) disable iff (rst)
        !pg_ok |=> (gate_cmd == GATE_OFF && ramp_code == '0));

    // R2: with supply present the ramp moves by at most one code per cycle
    p_ramp_slew_r2: assert property (@(posedge clk) disable iff (rst)
        pg_ok |=> (ramp_code == $past(ramp_code) ||
                   ramp_code == $past(ramp_code) + ONE ||
                   ramp_code == $past(ramp_code) - ONE));

    // R2: the ramp never passes its top code
    p_ramp_ceiling_r2: assert property (@(posedge clk) disable iff (rst)
        ramp_code <= TOP_C);

    // R2: fixed reference is chosen only once the ramp has reached it
    p_ref_handover_r2: assert property (@(posedge clk) disable iff (rst)
        (gate_cmd == GATE_SWITCH && !ramp_sel) |-> ramp_code >= REF_C);

    // R1: the off state is quiet
    p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (gate_cmd == GATE_OFF) |-> (ramp_code == '0 && !sink_en));

    // R7: over-voltage seen while switching forces the low-side on next
    p_ov_clamp_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(gate_cmd) == GATE_SWITCH && $past(fb_code) > OV_TRIP &&
         gate_cmd != GATE_OFF) |-> gate_cmd == GATE_LOWON);

endmodule

bind buck_seq_ctrl buck_seq_ctrl_chk #(
    .CODE_W(CODE_W), .REF_CODE(REF_CODE), .TOP_CODE(TOP_CODE)
) u_chk (
    .clk(clk), .rst(rst), .pg_ok(pg_ok), .fb_code(fb_code),
    .ramp_code(ramp_code), .ramp_sel(ramp_sel), .sink_en(sink_en),
    .gate_cmd(gate_cmd)
);

// File: tb/buck_seq_ctrl_test.sv
module buck_seq_ctrl_test;
    localparam int CW  = 10;
    localparam int TW  = 8;
    localparam int REF = 819;
    localparam int TOP = 973;
    localparam int DIV = 2;
    localparam int HIC = 60;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic          pg  = 1'b1;
    logic [CW-1:0] fb  = '0;
    logic [TW-1:0] temp = 8'd25;
    logic [CW-1:0] ramp;
    logic          rsel, sink;
    logic [1:0]    gate;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    buck_seq_ctrl #(
        .CODE_W(CW), .TEMP_W(TW), .REF_CODE(REF), .TOP_CODE(TOP),
        .STEP_DIV(DIV), .UV_FILT(20), .HICCUP_CYC(HIC),
        .TEMP_TRIP(150), .TEMP_HYST(40)
    ) uut (
        .clk(clk), .rst(rst), .en(en), .pg_ok(pg), .fb_code(fb),
        .temp_code(temp), .ramp_code(ramp), .ramp_sel(rsel),
        .sink_en(sink), .gate_cmd(gate)
    );

    always #10 clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_ramp(input int v);
        for (int i = 0; i < 6000 && int'(ramp) != v; i++) step(1);
    endtask

    task automatic t_reset;
        step(5);
        rst = 1'b0;
        step(2);
        check("R1", "gate after reset", gate, 0);
        check("R1", "ramp after reset", ramp, 0);
        check("R1", "sink after reset", sink, 0);
        check("R1", "ramp_sel after reset", rsel, 1);
    endtask

    task automatic t_start_gating;
        en = 1'b1; pg = 1'b0;
        step(20);
        check("R1", "gate with supply low", gate, 0);
        pg = 1'b1; temp = 8'd150;
        step(20);
        check("R8", "gate while hot at start", gate, 0);
        temp = 8'd25;
        step(4);
        check("R1", "gate once allowed", gate, 1);
    endtask

    task automatic t_soft_start;
        int r0;
        step(DIV * 4);
        r0 = ramp;
        step(DIV);
        check("R2", "one step per STEP_DIV", ramp, r0 + 1);
        wait_ramp(REF - 1);
        check("R2", "ramp_sel below ref", rsel, 1);
        check("R3", "sink off before target", sink, 0);
        wait_ramp(REF);
        check("R2", "ramp_sel at ref", rsel, 0);
        fb = CW'(REF);
        step(2);
        check("R3", "sink on after target", sink, 1);
        wait_ramp(TOP);
        step(DIV * 5);
        check("R2", "ramp holds top", ramp, TOP);
        check("R2", "fixed ref in regulation", rsel, 0);
    endtask

    task automatic t_undervoltage;
        int cnt;
        fb = 10'd300;
        step(15);
        fb = CW'(REF);
        step(30);
        check("R5", "short dip ignored (sel)", rsel, 0);
        check("R5", "short dip ignored (ramp)", ramp, TOP);
        fb = 10'd300;
        step(30);
        check("R5", "long dip starts stop", rsel, 1);
        check("R3", "sink held during stop", sink, 1);
        wait_ramp(0);
        step(2);
        check("R6", "low-side on after uv stop", gate, 2);
        cnt = 0;
        while (gate == 2'b10 && cnt < 1000) begin
            step(1);
            cnt++;
        end
        check("R6", "hiccup delay in window", (cnt >= HIC - 4 && cnt <= HIC + 2) ? 1 : 0, 1);
        check("R6", "auto restart switching", gate, 1);
        wait_ramp(TOP - 3);
        fb = CW'(REF);
        wait_ramp(TOP);
        step(4);
        check("R5", "low fb in start causes no stop", ramp, TOP);
    endtask

    task automatic t_overvoltage;
        fb = 10'd1010;
        step(2);
        check("R7", "clamp on trip", gate, 2);
        fb = 10'd900;
        step(4);
        check("R7", "clamp held in band", gate, 2);
        fb = 10'd850;
        step(2);
        check("R7", "clamp released", gate, 1);
        check("R7", "no restart after clamp", ramp, TOP);
    endtask

    task automatic t_thermal;
        temp = 8'd150;
        step(3);
        check("R8", "soft-stop on hot", rsel, 1);
        check("R8", "switching during thermal stop", gate, 1);
        wait_ramp(0);
        step(2);
        check("R8", "both off after thermal stop", gate, 0);
        temp = 8'd120;
        step(20);
        check("R8", "no restart above clear point", gate, 0);
        temp = 8'd110;
        step(3);
        check("R8", "restart at clear point", gate, 1);
        wait_ramp(TOP);
        step(3);
    endtask

    task automatic t_enable_stop;
        en = 1'b0;
        step(3);
        check("R4", "stop begins on enable low", rsel, 1);
        check("R4", "switching during stop", gate, 1);
        wait_ramp(0);
        step(2);
        check("R4", "low-side on after stop", gate, 2);
        step(100);
        check("R4", "low-side still held", gate, 2);
        check("R4", "ramp held at zero", ramp, 0);
        en = 1'b1;
        step(3);
        check("R4", "restart on enable high", gate, 1);
    endtask

    task automatic t_supply_loss;
        step(50);
        check("R9", "ramp moving before loss", (ramp > 0) ? 1 : 0, 1);
        pg = 1'b0;
        step(1);
        check("R9", "gate off at once", gate, 0);
        check("R9", "ramp cleared at once", ramp, 0);
        pg = 1'b1;
        step(3);
        check("R1", "start again with supply back", gate, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_start_gating();
        t_soft_start();
        t_undervoltage();
        t_overvoltage();
        t_thermal();
        t_enable_stop();
        t_supply_loss();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule